// File: doc/BRIEF.md
# Fundamental and Third-Harmonic Synchronous-Frame Current Controller

This block runs the inner current loop of one converter leg, digitally, in two rotating frames at once. On every sample strobe it takes the leg current error (reference minus measured) as the alpha component. It builds two beta components from delayed copies of that same error. A delay of one quarter of a fundamental period gives 90° at the fundamental. A delay of one twelfth of a period gives 90° at the third harmonic. The period is 156 samples, so the two delays are 39 and 13 samples, both whole numbers.

Each alpha/beta pair is rotated into d-q coordinates. The fundamental pair uses the angle θ and the third-harmonic pair uses 3θ. The cosine and sine of both angles come from outside the block. In the rotating frame the wanted component becomes a constant. A moving sum over half a fundamental period removes the ripple left at even multiples of the line frequency. A PI law with a clamped integrator then acts on each of the four filtered channels. The four PI outputs are rotated back to the stationary frame. The fundamental and third-harmonic alpha parts are added and saturated to the modulator range. The result is presented as a modulation command one clock after the strobe.

The 1/N scaling of the moving average is folded into the integer PI gains, so the PI acts directly on the window sum. Angle generation and the PWM stage sit outside this block.

Top module: `harm_dq_loop`

## Requirements
- R1: The alpha input on each strobe is e = ref_i − meas_i, formed at 13-bit signed precision from the two 12-bit signed inputs.
- R2: The fundamental beta is the error from exactly 39 strobes earlier. The third-harmonic beta is the error from exactly 13 strobes earlier. While that many samples have not yet been taken since reset, each beta is 0.
- R3: The rotation uses cos/sin of θ (cos1_i/sin1_i) for the fundamental pair and cos/sin of 3θ (cos3_i/sin3_i) for the third-harmonic pair. All four are signed Q1.15 values. The outputs are d = (α·c + β·s) >>> 15 and q = (β·c − α·s) >>> 15, using arithmetic (floor) shifts.
- R4: Each of the four channels (fundamental d, fundamental q, third-harmonic d, third-harmonic q) keeps the sum S of its 78 most recent rotated values. This window is half a fundamental period. Samples not yet taken since reset count as 0.
- R5: Each channel's integrator updates as A ← clamp(A + 172·S, ±2^34). The channel output is u = (12905·S + A) >>> 24, computed with the new A. The gains correspond to a proportional gain of 0.06 and an integral time of 8 ms at 156 samples per 60 Hz cycle, with the 1/78 window scaling folded in.
- R6: Each loop is rotated back as a = (u_d·c − u_q·s) >>> 15, using that loop's own angle. The command is the sum of the two loops' a values, saturated to the range −2047 to +2047.
- R7: cmd_valid is high for exactly the one clock that follows each clock in which strobe is high. cmd takes its new value at that same edge.
- R8: Reset (rst_n low) clears cmd, cmd_valid, the error history, the window contents and sums, and all integrators.
- R9: In a clock without strobe, changes on ref_i, meas_i or the angle inputs have no effect. cmd holds its value, and no history, window or integrator state advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Sample strobe, one clock per control sample |
| ref_i | input | 12 | Signed reference leg current |
| meas_i | input | 12 | Signed measured leg current |
| cos1_i | input | 16 | Signed Q1.15 cosine of θ |
| sin1_i | input | 16 | Signed Q1.15 sine of θ |
| cos3_i | input | 16 | Signed Q1.15 cosine of 3θ |
| sin3_i | input | 16 | Signed Q1.15 sine of 3θ |
| cmd | output | 12 | Signed saturated modulation command |
| cmd_valid | output | 1 | One-clock pulse marking a new command |

## Verification
The assertions check the following on every cycle:
- cmd_valid follows the strobe with a one-clock delay, and stays low otherwise.
- cmd is frozen between strobes.
- Every integrator stays inside its clamp.
- The command stays inside the modulator range.
- The history pointer stays within the quarter-period buffer.

Only the bench's scenarios can show the following:
- Both delay taps pick the right past samples.
- Each rotation uses its own angle pair.
- The half-period window sum forgets exactly the oldest sample.
- The PI and back-rotation arithmetic give the exact command values.

These scenarios are a constant error that drives the integrators into the clamp, a fundamental-plus-third-harmonic error with rotating angles, back-to-back strobes and strobe gaps with changing inputs, and a reset in mid-run.

// File: rtl/harm_dq_loop.sv
module harm_dq_loop #(
  parameter int DW      = 12,
  parameter int CW      = 16,
  parameter int SPP     = 156,
  parameter int KP      = 12905,
  parameter int KI      = 172,
  parameter int GSH     = 24,
  parameter int ILIM_SH = 34
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strobe,
  input  logic signed [DW-1:0] ref_i,
  input  logic signed [DW-1:0] meas_i,
  input  logic signed [CW-1:0] cos1_i,
  input  logic signed [CW-1:0] sin1_i,
  input  logic signed [CW-1:0] cos3_i,
  input  logic signed [CW-1:0] sin3_i,
  output logic signed [DW-1:0] cmd,
  output logic                 cmd_valid
);
  localparam int EW  = DW + 1;
  localparam int QTR = SPP / 4;
  localparam int TWL = SPP / 12;
  localparam int WIN = SPP / 2;
  localparam int RW  = DW + 3;
  localparam int SW  = RW + $clog2(WIN) + 1;
  localparam int AW  = 48;
  localparam int QAW = $clog2(QTR);
  localparam int WAW = $clog2(WIN);
  localparam int FS  = CW - 1;
  localparam logic signed [AW-1:0] ILIM = AW'(1) <<< ILIM_SH;
  localparam logic signed [AW-1:0] CLIM = AW'((1 << (DW - 1)) - 1);

  logic signed [EW-1:0] err;
  logic signed [EW-1:0] hist [QTR];
  logic [QAW-1:0]       wp, tap3;
  logic [QAW:0]         t3s;
  logic [WAW-1:0]       mp;
  logic signed [EW-1:0] beta [2];
  logic signed [CW-1:0] cs [2];
  logic signed [CW-1:0] sn [2];
  logic signed [RW-1:0] rot [4];
  logic signed [AW-1:0] u [4];
  logic signed [AW-1:0] alph [2];
  logic signed [AW-1:0] tot, cmd_nx;

  assign err = EW'(ref_i) - EW'(meas_i);

  assign t3s  = {1'b0, wp} + (QAW+1)'(QTR - TWL);
  assign tap3 = (t3s >= (QAW+1)'(QTR)) ? QAW'(t3s - (QAW+1)'(QTR)) : QAW'(t3s);
  assign beta[0] = hist[wp];
  assign beta[1] = hist[tap3];
  assign cs[0] = cos1_i;
  assign sn[0] = sin1_i;
  assign cs[1] = cos3_i;
  assign sn[1] = sin3_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      mp <= '0;
      for (int i = 0; i < QTR; i++) hist[i] <= '0;
    end else if (strobe) begin
      hist[wp] <= err;
      wp <= (wp == QAW'(QTR - 1)) ? '0 : wp + 1'b1;
      mp <= (mp == WAW'(WIN - 1)) ? '0 : mp + 1'b1;
    end
  end

  p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wp < QAW'(QTR)) && (mp < WAW'(WIN)))
    else $error("history or window pointer out of range");

  for (genvar k = 0; k < 2; k++) begin : g_rot
    logic signed [AW-1:0] dfull, qfull;
    assign dfull = (AW'(err) * AW'(cs[k]) + AW'(beta[k]) * AW'(sn[k])) >>> FS;
    assign qfull = (AW'(beta[k]) * AW'(cs[k]) - AW'(err) * AW'(sn[k])) >>> FS;
    assign rot[2*k]   = RW'(dfull);
    assign rot[2*k+1] = RW'(qfull);
    assign alph[k] = (u[2*k] * AW'(cs[k]) - u[2*k+1] * AW'(sn[k])) >>> FS;
  end

  for (genvar ch = 0; ch < 4; ch++) begin : g_ch
    logic signed [RW-1:0] mb [WIN];
    logic signed [SW-1:0] sm, sm_nx;
    logic signed [AW-1:0] acc, s_w, acc_t, acc_nx;

    assign sm_nx  = sm + SW'(rot[ch]) - SW'(mb[mp]);
    assign s_w    = AW'(sm_nx);
    assign acc_t  = acc + AW'(KI) * s_w;
    assign acc_nx = (acc_t > ILIM) ? ILIM : ((acc_t < -ILIM) ? -ILIM : acc_t);
    assign u[ch]  = (AW'(KP) * s_w + acc_nx) >>> GSH;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sm  <= '0;
        acc <= '0;
        for (int i = 0; i < WIN; i++) mb[i] <= '0;
      end else if (strobe) begin
        mb[mp] <= rot[ch];
        sm     <= sm_nx;
        acc    <= acc_nx;
      end
    end

    p_integ_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc <= ILIM) && (acc >= -ILIM))
      else $error("integrator outside clamp");
  end

  assign tot    = alph[0] + alph[1];
  assign cmd_nx = (tot > CLIM) ? CLIM : ((tot < -CLIM) ? -CLIM : tot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd       <= '0;
      cmd_valid <= 1'b0;
    end else begin
      cmd_valid <= strobe;
      if (strobe) cmd <= DW'(cmd_nx);
    end
  end

  p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> cmd_valid)
    else $error("missing valid pulse after strobe");
  p_valid_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> !cmd_valid)
    else $error("valid without strobe");
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(cmd))
    else $error("command changed without strobe");
  p_cmd_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (AW'(cmd) <= CLIM) && (AW'(cmd) >= -CLIM))
    else $error("command outside modulator range");
endmodule

// File: tb/test_harm_dq_loop.sv
module test_harm_dq_loop;
  localparam int QTR = 39;
  localparam int TWL = 13;
  localparam int WIN = 78;
  localparam longint KP = 12905;
  localparam longint KI = 172;
  localparam longint ILIM = 64'sd1 <<< 34;
  localparam real PI2 = 6.283185307179586;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic signed [11:0] ref_i = '0, meas_i = '0;
  logic signed [15:0] cos1_i = '0, sin1_i = '0, cos3_i = '0, sin3_i = '0;
  logic signed [11:0] cmd;
  logic cmd_valid;

  harm_dq_loop i_harm_dq_loop (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .ref_i(ref_i), .meas_i(meas_i),
    .cos1_i(cos1_i), .sin1_i(sin1_i), .cos3_i(cos3_i), .sin3_i(sin3_i),
    .cmd(cmd), .cmd_valid(cmd_valid));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  string tag = "R8";

  longint eq[$];
  longint wq[4][$];
  longint acc[4];
  longint exp_cmd = 0;
  bit exp_valid = 0;

  function automatic void model_reset();
    eq.delete();
    for (int c = 0; c < 4; c++) begin wq[c].delete(); acc[c] = 0; end
    exp_cmd = 0;
    exp_valid = 0;
  endfunction

  function automatic void model_sample(longint a, longint b, longint c1, longint s1,
                                       longint c3, longint s3);
    longint e, bt[2], c[2], s[2], rv[4], u[4], sum, tot;
    e = a - b;
    bt[0] = (eq.size() >= QTR) ? eq[QTR-1] : 0;
    bt[1] = (eq.size() >= TWL) ? eq[TWL-1] : 0;
    eq.push_front(e);
    if (eq.size() > QTR) void'(eq.pop_back());
    c[0] = c1; s[0] = s1; c[1] = c3; s[1] = s3;
    for (int k = 0; k < 2; k++) begin
      rv[2*k]   = (e * c[k] + bt[k] * s[k]) >>> 15;
      rv[2*k+1] = (bt[k] * c[k] - e * s[k]) >>> 15;
    end
    for (int ch = 0; ch < 4; ch++) begin
      wq[ch].push_front(rv[ch]);
      if (wq[ch].size() > WIN) void'(wq[ch].pop_back());
      sum = 0;
      foreach (wq[ch][i]) sum += wq[ch][i];
      acc[ch] += KI * sum;
      if (acc[ch] > ILIM) acc[ch] = ILIM;
      if (acc[ch] < -ILIM) acc[ch] = -ILIM;
      u[ch] = (KP * sum + acc[ch]) >>> 24;
    end
    tot = 0;
    for (int k = 0; k < 2; k++) tot += (u[2*k] * c[k] - u[2*k+1] * s[k]) >>> 15;
    if (tot > 2047) tot = 2047;
    if (tot < -2047) tot = -2047;
    exp_cmd = tot;
    exp_valid = 1;
  endfunction

  task automatic compare();
    checks++;
    if (cmd_valid !== exp_valid) begin
      errors++;
      $display("FAIL R7 cmd_valid=%0b expected=%0b (%s)", cmd_valid, exp_valid, tag);
    end
    checks++;
    if (longint'(cmd) !== exp_cmd) begin
      errors++;
      $display("FAIL %s cmd=%0d expected=%0d", tag, cmd, exp_cmd);
    end
  endtask

  task automatic step(bit r, bit s, int a, int b, int c1, int s1, int c3, int s3);
    @(negedge clk);
    compare();
    rst_n = r; strobe = s;
    ref_i = 12'(a); meas_i = 12'(b);
    cos1_i = 16'(c1); sin1_i = 16'(s1); cos3_i = 16'(c3); sin3_i = 16'(s3);
    if (!r) model_reset();
    else if (s) model_sample(a, b, c1, s1, c3, s3);
    else exp_valid = 0;
  endtask

  task automatic angles(int n, output int c1, output int s1, output int c3, output int s3);
    real th;
    th = PI2 * real'(n % 156) / 156.0;
    c1 = $rtoi(32000.0 * $cos(th));
    s1 = $rtoi(32000.0 * $sin(th));
    c3 = $rtoi(32000.0 * $cos(3.0 * th));
    s3 = $rtoi(32000.0 * $sin(3.0 * th));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int c1, s1, c3, s3;
    real th;
    // R8: reset state
    tag = "R8";
    model_reset();
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);

    // R1 R4 R5 R6: constant error, fixed angle, integrators into clamp
    tag = "R1/R4/R5/R6 constant error";
    for (int n = 0; n < 800; n++) begin
      step(1, 1, 1500 - (n % 3), -500, 32767, 0, 32767, 0);
      step(1, 0, 0, 0, 0, 0, 0, 0);
    end

    // R8: reset in mid-run clears history and integrators
    tag = "R8 mid-run reset";
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 32767, 0, 32767, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);

    // R2 R3: fundamental plus third harmonic with rotating angles
    tag = "R2/R3 rotating";
    for (int n = 0; n < 500; n++) begin
      angles(n, c1, s1, c3, s3);
      th = PI2 * real'(n % 156) / 156.0;
      step(1, 1, $rtoi(700.0 * $cos(th + 0.3) + 350.0 * $cos(3.0 * th - 0.5)),
           $rtoi(250.0 * $cos(th)), c1, s1, c3, s3);
      step(1, 0, 0, 0, 0, 0, 0, 0);
    end

    // R7: back-to-back strobes
    tag = "R7 back-to-back";
    for (int n = 0; n < 60; n++) begin
      angles(n * 7, c1, s1, c3, s3);
      step(1, 1, (n * 37) % 900 - 450, (n * 11) % 300, c1, s1, c3, s3);
    end

    // R9: inputs moving without strobe have no effect
    tag = "R9 no strobe";
    for (int n = 0; n < 40; n++)
      step(1, 0, (n * 97) % 2000 - 1000, (n * 53) % 1500 - 700,
           n * 800 - 16000, 16000 - n * 700, n * 300, -n * 500);
    tag = "R9/R2 after idle";
    for (int n = 0; n < 30; n++) begin
      angles(n * 5, c1, s1, c3, s3);
      step(1, 1, 300 - n * 20, -100, c1, s1, c3, s3);
      step(1, 0, 1234, -999, 5, 6, 7, 8);
      step(1, 0, -777, 555, -9, 10, -11, 12);
    end
    tag = "R7 tail";
    step(1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule